// File: doc/BRIEF.md
# Programmable SONET/SDH Frame Pulse Generator

This block produces the frame reference strobe that travels with an outgoing SONET/SDH receive data stream. The stream leaves on a parallel bus in one of two shapes: a wide lane that carries one byte pair per clock, or a narrow lane that carries one nibble per clock, most significant nibble first. An upstream framer marks the first unit of every 125 us frame with `frame_start`. The block counts bus cycles from that mark and raises `frame_pulse` for one clock at a position chosen by software.

Two position modes are offered. In overhead mode the strobe lands on a chosen byte of the first row of the transport overhead. On the wide bus that is the byte pair containing the chosen byte; on the narrow bus it is the upper nibble of the chosen byte. In payload mode the strobe lands on the first payload byte instead. The byte offset of that byte from the frame start comes from an external pointer processor. A rate select chooses STS-48 (N=48) or STS-192 (N=192). N sets the row size (90·N bytes), the overhead width (3·N bytes) and the frame length (9 rows).

All settings are captured on the cycle that carries `frame_start` and hold for that frame. Between frame starts the counter runs on by itself, one frame length at a time.

Top module: `fpg_frame_pulse`

## Requirements
- R1: While reset is held, and after reset until the first cycle with `frame_start` high, `frame_pulse` stays 0.
- R2: `frame_pulse` is high for exactly one clock per frame. It is registered and changes only on the rising clock edge.
- R3: On the wide bus (`narrow_mode`=0) in overhead mode (`use_payload`=0), `frame_pulse` is high after the edge k cycles past the edge that samples `frame_start`, with k = floor(`pos_col`/2). k=0 means the same edge.
- R4: On the wide bus in overhead mode, a `pos_col` of 3·N or more is treated as 3·N−1, so k = 3·N/2 − 1.
- R5: On the narrow bus (`narrow_mode`=1) in overhead mode, k = 2·`pos_col`, which is always even: the upper nibble. `pos_col` is clamped to 3·N−1 as in R4.
- R6: In payload mode (`use_payload`=1), k = floor(`payload_off`/2) on the wide bus and k = 2·`payload_off` on the narrow bus. `payload_off` is clamped to 9·90·N − 1.
- R7: `rate_sel`=0 selects N=48 and `rate_sel`=1 selects N=192. This sets the clamp limits of R4 to R6 and the frame length of R9.
- R8: `pos_col`, `payload_off`, `use_payload`, `narrow_mode` and `rate_sel` are sampled only on an edge where `frame_start` is high. A change in mid-frame moves the pulse from the next frame start onward.
- R9: With no further `frame_start`, the pulse recurs every frame length: 9·90·N/2 cycles on the wide bus and 9·90·N·2 cycles on the narrow bus.
- R10: A `frame_start` in mid-frame restarts the count. The pulse then appears k cycles after the new start and not at the old position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Marks the first bus unit of a frame |
| narrow_mode | input | 1 | 0: byte pair per cycle, 1: nibble per cycle |
| rate_sel | input | 1 | 0: STS-48, 1: STS-192 |
| use_payload | input | 1 | 0: overhead position, 1: first payload byte |
| pos_col | input | 15 | Chosen first-row byte column (overhead mode) |
| payload_off | input | 18 | Byte offset of the first payload byte from frame start |
| frame_pulse | output | 1 | Single-cycle frame reference strobe |

## Verification
On every cycle, the assertions check that the strobe never lasts two cycles unless a new frame start caused it. They also check that it stays low before the first frame start and that the cycle position never leaves the frame length. Finally, they check that the computed narrow-bus target is always even, and that the wide overhead target never passes the last overhead byte pair.

Only the bench's scenarios can show that the strobe lands on the exact cycle for each mode, rate and clamp. The same holds for mid-frame settings waiting for the next frame start, for a restart moving the strobe, and for the strobe recurring one full frame later.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
   typedef enum logic {BUS_WIDE = 1'b0, BUS_NARROW = 1'b1} bus_shape_e;
   typedef enum logic {RATE_LO = 1'b0, RATE_HI = 1'b1} line_rate_e;
   typedef enum logic {POS_OVERHEAD = 1'b0, POS_PAYLOAD = 1'b1} pos_mode_e;
endpackage

// File: rtl/fpg_target.sv
module fpg_target
   import fpg_pkg::*;
#(
   parameter int N_LO       = 48,
   parameter int N_HI       = 192,
   parameter int ROWS       = 9,
   parameter int COLS_PER_N = 90,
   parameter int OH_PER_N   = 3,
   parameter int COL_W      = 15,
   parameter int OFF_W      = 18,
   parameter int CNT_W      = 19
) (
   input  logic             narrow_mode,
   input  logic             rate_sel,
   input  logic             use_payload,
   input  logic [COL_W-1:0] pos_col,
   input  logic [OFF_W-1:0] payload_off,
   output logic [CNT_W-1:0] tgt,
   output logic [CNT_W-1:0] len
);
   logic [COL_W-1:0] oh_last    [2];
   logic [OFF_W-1:0] frame_last [2];
   logic [CNT_W-1:0] len_wide   [2];
   logic [CNT_W-1:0] len_narrow [2];

   for (genvar g = 0; g < 2; g++) begin : g_rate
      localparam int NN     = (g == 0) ? N_LO : N_HI;
      localparam int FBYTES = ROWS * COLS_PER_N * NN;
      assign oh_last[g]    = COL_W'(OH_PER_N * NN - 1);
      assign frame_last[g] = OFF_W'(FBYTES - 1);
      assign len_wide[g]   = CNT_W'(FBYTES / 2);
      assign len_narrow[g] = CNT_W'(FBYTES * 2);
   end

   logic [COL_W-1:0] col_c;
   logic [OFF_W-1:0] off_c;
   logic [CNT_W-1:0] byte_idx;
   logic             r;

   always_comb begin
      r        = rate_sel;
      col_c    = (pos_col > oh_last[r]) ? oh_last[r] : pos_col;
      off_c    = (payload_off > frame_last[r]) ? frame_last[r] : payload_off;
      byte_idx = (pos_mode_e'(use_payload) == POS_PAYLOAD) ? CNT_W'(off_c) : CNT_W'(col_c);
      if (bus_shape_e'(narrow_mode) == BUS_NARROW) begin
         tgt = byte_idx << 1;
         len = len_narrow[r];
      end else begin
         tgt = byte_idx >> 1;
         len = len_wide[r];
      end
   end
endmodule

// File: rtl/fpg_pos_counter.sv
module fpg_pos_counter #(
   parameter int CNT_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic [CNT_W-1:0] tgt_new,
   input  logic [CNT_W-1:0] len_new,
   output logic [CNT_W-1:0] pos,
   output logic [CNT_W-1:0] tgt_cur,
   output logic             active
);
   logic [CNT_W-1:0] cnt_q, len_q, tgt_q;
   logic             run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= '0;
         tgt_q <= '0;
         run_q <= 1'b0;
      end else if (frame_start) begin
         cnt_q <= CNT_W'(1);
         len_q <= len_new;
         tgt_q <= tgt_new;
         run_q <= 1'b1;
      end else if (run_q) begin
         cnt_q <= (cnt_q == len_q - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
      end
   end

   assign pos     = frame_start ? '0 : cnt_q;
   assign tgt_cur = frame_start ? tgt_new : tgt_q;
   assign active  = run_q;

   // R9: the flywheel position stays inside the latched frame length
   a_r9_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !frame_start) |-> (cnt_q < len_q));
endmodule

// File: rtl/fpg_frame_pulse.sv
module fpg_frame_pulse
   import fpg_pkg::*;
#(
   parameter int N_LO       = 48,
   parameter int N_HI       = 192,
   parameter int ROWS       = 9,
   parameter int COLS_PER_N = 90,
   parameter int OH_PER_N   = 3,
   localparam int ROW_HI    = COLS_PER_N * N_HI,
   localparam int FRAME_HI  = ROWS * ROW_HI,
   localparam int COL_W     = $clog2(ROW_HI),
   localparam int OFF_W     = $clog2(FRAME_HI),
   localparam int CNT_W     = $clog2(FRAME_HI * 2 + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             narrow_mode,
   input  logic             rate_sel,
   input  logic             use_payload,
   input  logic [COL_W-1:0] pos_col,
   input  logic [OFF_W-1:0] payload_off,
   output logic             frame_pulse
);
   if (N_LO < 2 || N_HI < N_LO) begin : g_bad_rate
      $error("fpg_frame_pulse: rate factors out of order");
   end
   if ((N_LO % 2) != 0 || (N_HI % 2) != 0) begin : g_bad_pair
      $error("fpg_frame_pulse: N must be even for byte-pair lanes");
   end
   if (OH_PER_N < 1 || OH_PER_N >= COLS_PER_N || ROWS < 1) begin : g_bad_geom
      $error("fpg_frame_pulse: frame geometry invalid");
   end

   logic [CNT_W-1:0] tgt_new, len_new, pos, tgt_cur;
   logic             active, hit;

   fpg_target #(
      .N_LO(N_LO), .N_HI(N_HI), .ROWS(ROWS), .COLS_PER_N(COLS_PER_N),
      .OH_PER_N(OH_PER_N), .COL_W(COL_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
   ) u_target (
      .narrow_mode (narrow_mode),
      .rate_sel    (rate_sel),
      .use_payload (use_payload),
      .pos_col     (pos_col),
      .payload_off (payload_off),
      .tgt         (tgt_new),
      .len         (len_new)
   );

   fpg_pos_counter #(.CNT_W(CNT_W)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .tgt_new     (tgt_new),
      .len_new     (len_new),
      .pos         (pos),
      .tgt_cur     (tgt_cur),
      .active      (active)
   );

   assign hit = (frame_start || active) && (pos == tgt_cur);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_pulse <= 1'b0;
      else        frame_pulse <= hit;
   end

   localparam int OH_PAIR_LO = (OH_PER_N * N_LO) / 2 - 1;
   localparam int OH_PAIR_HI = (OH_PER_N * N_HI) / 2 - 1;

   // R1: nothing before the first frame start
   a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !frame_pulse);
   // R2: strobe lasts one cycle unless a fresh frame start re-arms it
   a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_pulse && !frame_start) |=> !frame_pulse);
   // R5: narrow-bus target always falls on an upper nibble
   a_r5_upper_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      narrow_mode |-> !tgt_new[0]);
   // R4: wide overhead target never passes the last overhead byte pair
   a_r4_clamp_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (!narrow_mode && !use_payload && !rate_sel) |-> (tgt_new <= CNT_W'(OH_PAIR_LO)));
   a_r4_clamp_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (!narrow_mode && !use_payload && rate_sel) |-> (tgt_new <= CNT_W'(OH_PAIR_HI)));
endmodule

// File: tb/tb_fpg_frame_pulse.sv
module tb_fpg_frame_pulse;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        narrow_mode = 1'b0;
   logic        rate_sel = 1'b0;
   logic        use_payload = 1'b0;
   logic [14:0] pos_col = '0;
   logic [17:0] payload_off = '0;
   logic        frame_pulse;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   fpg_frame_pulse dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .narrow_mode(narrow_mode), .rate_sel(rate_sel), .use_payload(use_payload),
      .pos_col(pos_col), .payload_off(payload_off), .frame_pulse(frame_pulse)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog R2 actual=%0d expected=finished", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic        nar;
      logic        rate;
      logic        pl;
      logic [14:0] col;
      logic [17:0] off;
      logic [31:0] k;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 1'b0, 15'd0,    18'd0,      32'd0,     8'd3},  // R3 first pair
      '{1'b0, 1'b0, 1'b0, 15'd5,    18'd0,      32'd2,     8'd3},  // R3 odd byte -> pair 2
      '{1'b0, 1'b0, 1'b0, 15'd143,  18'd0,      32'd71,    8'd3},  // R3 last byte, N=48
      '{1'b0, 1'b0, 1'b0, 15'd200,  18'd0,      32'd71,    8'd4},  // R4 clamp N=48
      '{1'b0, 1'b1, 1'b0, 15'd200,  18'd0,      32'd100,   8'd7},  // R7 no clamp at N=192
      '{1'b0, 1'b1, 1'b0, 15'd1000, 18'd0,      32'd287,   8'd4},  // R4 clamp N=192
      '{1'b1, 1'b0, 1'b0, 15'd3,    18'd0,      32'd6,     8'd5},  // R5 upper nibble
      '{1'b1, 1'b0, 1'b0, 15'd150,  18'd0,      32'd286,   8'd5},  // R5 clamp N=48
      '{1'b1, 1'b1, 1'b0, 15'd575,  18'd0,      32'd1150,  8'd5},  // R5 last byte N=192
      '{1'b0, 1'b0, 1'b1, 15'd3,    18'd1000,   32'd500,   8'd6},  // R6 wide payload
      '{1'b1, 1'b1, 1'b1, 15'd3,    18'd321,    32'd642,   8'd6},  // R6 narrow payload
      '{1'b1, 1'b0, 1'b1, 15'd9,    18'd4,      32'd8,     8'd6},  // R6 narrow small
      '{1'b0, 1'b0, 1'b1, 15'd0,    18'd40000,  32'd19439, 8'd6}   // R6 offset clamp
   };

   // Starts a frame and watches win cycles; i=0 is the edge sampling frame_start.
   task automatic run_frame(input logic nar, input logic rate, input logic pl,
                            input logic [14:0] col, input logic [17:0] off,
                            input int win, input int chg_at, input logic [14:0] new_col,
                            input int rs_at,
                            output int cnt, output int first, output int last);
      @(negedge clk);
      narrow_mode = nar; rate_sel = rate; use_payload = pl;
      pos_col = col; payload_off = off; frame_start = 1'b1;
      cnt = 0; first = -1; last = -1;
      for (int i = 0; i < win; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (i == 0) frame_start = 1'b0;
         if (i == chg_at) pos_col = new_col;
         if (i == rs_at) frame_start = 1'b1;
         if (i == rs_at + 1) frame_start = 1'b0;
         if (frame_pulse) begin
            if (first < 0) first = i;
            last = i;
            cnt++;
         end
      end
   endtask

   initial begin
      int cnt, first, last, hits;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 pulse in reset", int'(frame_pulse), 0);
      rst_n = 1'b1;
      hits = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (frame_pulse) hits++;
      end
      check("R1 pulse before first frame start", hits, 0);

      // table of positions across modes, rates and clamps (R2..R7)
      for (int v = 0; v < NV; v++) begin
         run_frame(VECS[v].nar, VECS[v].rate, VECS[v].pl, VECS[v].col, VECS[v].off,
                   int'(VECS[v].k) + 4, -1, '0, -10, cnt, first, last);
         check($sformatf("R%0d vector %0d position", VECS[v].req, v), first, int'(VECS[v].k));
         check($sformatf("R2 vector %0d pulse count", v), cnt, 1);
      end

      // R8: mid-frame change waits for the next frame start
      run_frame(1'b0, 1'b0, 1'b0, 15'd20, '0, 20, 3, 15'd2, -10, cnt, first, last);
      check("R8 old position kept in current frame", first, 10);
      check("R8 single pulse in current frame", cnt, 1);
      run_frame(1'b0, 1'b0, 1'b0, 15'd2, '0, 6, -1, '0, -10, cnt, first, last);
      check("R8 new position after next start", first, 1);

      // R10: restart before the target moves the pulse
      run_frame(1'b0, 1'b0, 1'b0, 15'd40, '0, 35, -1, '0, 5, cnt, first, last);
      check("R10 pulse relative to restart", first, 6 + 20);
      check("R10 pulse count with restart", cnt, 1);

      // R9: flywheel recurrence, wide bus N=48 frame = 19440 cycles
      run_frame(1'b0, 1'b0, 1'b0, 15'd4, '0, 19450, -1, '0, -10, cnt, first, last);
      check("R9 first pulse", first, 2);
      check("R9 recurrence one frame later", last, 2 + 19440);
      check("R9 pulse count over two frames", cnt, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule